// File: doc/BRIEF.md
# Multiplexed Input Sample Selector

This block sits at the front of one receive channel. Its input bus carries up to eight data streams interleaved in time. A one-clock frame strobe marks the clock that holds the first stream of each frame. A 3-bit delay setting says how many clocks after the strobe the channel takes its sample. Delay 0 takes the sample on the strobe clock itself. Delay 7 takes it seven clocks later. Channels that share the bus but use different delay settings therefore each pick out a different stream.

The captured sample is not passed on at once. It is held and released in the clock after the next frame strobe. As a result, every channel hands its sample downstream on the same clock, whatever delay it uses.

Next to the sample, the block produces two per-clock update enables for the downstream oscillator and integrator stage. In gated mode, both enables follow the strobe. In interpolated mode, the integrator enable stays high on every clock, and the sample output is zero on every clock that does not carry a fresh sample.

Top module: `mux_stream_picker`

## Requirements
- R1: While reset is asserted, and in the first clock after it, out_sample, out_valid, osc_upd and integ_upd are all 0.
- R2: With a delay setting of 0, the captured value is the input present on the strobe clock itself.
- R3: With a delay setting d (1 to 7), the captured value is the input present d clocks after the strobe clock.
- R4: A value captured in one frame appears on out_sample in the clock after the next strobe. out_valid is high for exactly that one clock.
- R5: osc_upd is high in exactly the clocks that follow a strobe clock, in both modes.
- R6: In gated mode (mode bit 0), integ_upd equals osc_upd, and out_sample keeps its last value on every clock that does not follow a strobe.
- R7: In interpolated mode (mode bit 1), integ_upd is high on every clock, and out_sample is 0 on every clock where out_valid is low.
- R8: If a new strobe arrives before the delay count of the current frame has run out, the pending capture is dropped. The count restarts from the new strobe, and out_valid stays low after that strobe.
- R9: The delay and mode settings are sampled only on strobe clocks. A change between strobes affects neither the frame in progress nor the enables.
- R10: A strobe that has no captured value from a previous frame behind it, such as the first strobe after reset, leaves out_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | 16 | Multiplexed signed input sample bus |
| frame_stb | input | 1 | Frame strobe, high on the clock of the first stream |
| cfg_delay | input | 3 | Number of clocks after the strobe at which the sample is taken |
| cfg_interp | input | 1 | Mode select: 0 gated, 1 interpolated |
| out_sample | output | 16 | Realigned sample to the downstream stage |
| out_valid | output | 1 | High on the clock that carries a fresh sample |
| osc_upd | output | 1 | Oscillator update enable |
| integ_upd | output | 1 | Integrator update enable |

## Verification
The assertions assume only that the inputs hold known values once reset is released. They make no assumption about frame length. The strobe may come back on the very next clock, or stay high for several clocks in a row, and the assertions still hold. The stimulus uses frame lengths from 1 to 10 clocks, so frames that are shorter than the selected delay occur often and exercise the restart path. It also changes the delay and mode inputs on random clocks between strobes, so the rule that settings are sampled only at a strobe is exercised as well.

// File: rtl/stream_pick_pkg.sv
package stream_pick_pkg;

    typedef enum logic {
        UPD_GATED  = 1'b0,
        UPD_INTERP = 1'b1
    } upd_mode_e;

endpackage

// File: rtl/stream_tap.sv
module stream_tap #(
    parameter int SAMPLE_W = 16,
    parameter int DLY_W    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] din,
    input  logic                frame_stb,
    input  logic [DLY_W-1:0]    cfg_delay,
    output logic [SAMPLE_W-1:0] hold_data,
    output logic                hold_vld
);

    typedef struct packed {
        logic [DLY_W-1:0]    dly;
        logic [DLY_W-1:0]    cnt;
        logic                armed;
        logic [SAMPLE_W-1:0] data;
        logic                vld;
    } tap_state_t;

    tap_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (frame_stb) begin
            st_d.dly   = cfg_delay;
            st_d.cnt   = DLY_W'(1);
            st_d.armed = (cfg_delay != '0);
            st_d.vld   = (cfg_delay == '0);
            if (cfg_delay == '0) begin
                st_d.data = din;
            end
        end else if (st_q.armed) begin
            st_d.cnt = st_q.cnt + DLY_W'(1);
            if (st_q.cnt == st_q.dly) begin
                st_d.data  = din;
                st_d.vld   = 1'b1;
                st_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_data = st_q.data;
    assign hold_vld  = st_q.vld;

    // R8: a strobe with a non-zero delay throws away what was captured
    a_r8_stb_drops_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && cfg_delay != '0) |=> !hold_vld);

    // R4: a captured value stays put until a strobe comes
    a_r4_hold_until_stb: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_vld && !frame_stb) |=> (hold_vld && $stable(hold_data)));

    // R2: delay 0 takes the strobe-clock input
    a_r2_zero_delay_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && cfg_delay == '0) |=> (hold_vld && hold_data == $past(din)));

endmodule

// File: rtl/frame_aligner.sv
module frame_aligner
    import stream_pick_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_stb,
    input  logic                cfg_interp,
    input  logic [SAMPLE_W-1:0] hold_data,
    input  logic                hold_vld,
    output logic [SAMPLE_W-1:0] out_sample,
    output logic                out_valid,
    output logic                osc_upd,
    output logic                integ_upd
);

    typedef struct packed {
        upd_mode_e           mode;
        logic [SAMPLE_W-1:0] sample;
        logic                valid;
        logic                osc;
        logic                integ;
    } align_state_t;

    align_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.mode  = frame_stb ? upd_mode_e'(cfg_interp) : st_q.mode;
        st_d.valid = frame_stb && hold_vld;
        st_d.osc   = frame_stb;
        st_d.integ = frame_stb || (st_d.mode == UPD_INTERP);
        if (frame_stb && hold_vld) begin
            st_d.sample = hold_data;
        end else if (st_d.mode == UPD_INTERP) begin
            st_d.sample = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_sample = st_q.sample;
    assign out_valid  = st_q.valid;
    assign osc_upd    = st_q.osc;
    assign integ_upd  = st_q.integ;

    // R5: oscillator enable follows every strobe by one clock
    a_r5_osc_after_stb: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |=> osc_upd);

    a_r5_osc_needs_stb: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> !osc_upd);

    // R4: fresh data only right after a strobe
    a_r4_valid_after_stb: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> !out_valid);

    // R6: gated mode keeps the sample between strobes
    a_r6_gated_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == UPD_GATED && !frame_stb) |=> ($stable(out_sample) && !integ_upd));

    // R7: interpolated mode stuffs zeros and keeps the integrator running
    a_r7_interp_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == UPD_INTERP && !frame_stb) |=> (out_sample == '0 && integ_upd));

endmodule

// File: rtl/mux_stream_picker.sv
module mux_stream_picker #(
    parameter int SAMPLE_W = 16,
    parameter int DLY_W    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] din,
    input  logic                frame_stb,
    input  logic [DLY_W-1:0]    cfg_delay,
    input  logic                cfg_interp,
    output logic [SAMPLE_W-1:0] out_sample,
    output logic                out_valid,
    output logic                osc_upd,
    output logic                integ_upd
);

    logic [SAMPLE_W-1:0] hold_data;
    logic                hold_vld;

    stream_tap #(
        .SAMPLE_W (SAMPLE_W),
        .DLY_W    (DLY_W)
    ) i_tap (
        .clk       (clk),
        .rst_n     (rst_n),
        .din       (din),
        .frame_stb (frame_stb),
        .cfg_delay (cfg_delay),
        .hold_data (hold_data),
        .hold_vld  (hold_vld)
    );

    frame_aligner #(
        .SAMPLE_W (SAMPLE_W)
    ) i_align (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_stb  (frame_stb),
        .cfg_interp (cfg_interp),
        .hold_data  (hold_data),
        .hold_vld   (hold_vld),
        .out_sample (out_sample),
        .out_valid  (out_valid),
        .osc_upd    (osc_upd),
        .integ_upd  (integ_upd)
    );

    // R10: no fresh sample without a capture behind it
    a_r10_valid_needs_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && !hold_vld) |=> !out_valid);

endmodule

// File: tb/test_mux_stream_picker.sv
module test_mux_stream_picker;

    localparam int CLK_PERIOD = 10;
    localparam int SW = 16;
    localparam int DW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [SW-1:0] din = '0;
    logic          frame_stb = 1'b0;
    logic [DW-1:0] cfg_delay = '0;
    logic          cfg_interp = 1'b0;
    logic [SW-1:0] out_sample;
    logic          out_valid;
    logic          osc_upd;
    logic          integ_upd;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    // reference state
    int            m_since = -1;
    int            m_dly   = 0;
    bit            m_mode  = 1'b0;
    logic [SW-1:0] m_cap   = '0;
    bit            m_capv  = 1'b0;
    logic [SW-1:0] e_sample = '0;
    bit            e_valid = 1'b0;
    bit            e_osc   = 1'b0;
    bit            e_integ = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mux_stream_picker i_mux_stream_picker (
        .clk        (clk),
        .rst_n      (rst_n),
        .din        (din),
        .frame_stb  (frame_stb),
        .cfg_delay  (cfg_delay),
        .cfg_interp (cfg_interp),
        .out_sample (out_sample),
        .out_valid  (out_valid),
        .osc_upd    (osc_upd),
        .integ_upd  (integ_upd)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Expected outputs after one clock, built from R2..R10
    function automatic void model_step(input bit s, input logic [SW-1:0] x,
                                       input int d, input bit m);
        bit new_mode;
        new_mode = s ? m : m_mode;
        e_valid  = s && m_capv;
        e_osc    = s;
        e_integ  = s || new_mode;
        if (s && m_capv) e_sample = m_cap;
        else if (new_mode) e_sample = '0;
        if (s) begin
            m_dly   = d;
            m_since = 0;
            m_mode  = m;
            m_capv  = (d == 0);
            if (d == 0) m_cap = x;
        end else if (m_since >= 0) begin
            m_since++;
            if (m_dly != 0 && m_since == m_dly) begin
                m_cap  = x;
                m_capv = 1'b1;
            end
        end
    endfunction

    task automatic cyc(input bit s, input logic [SW-1:0] x, input int d,
                       input bit m, input string tag);
        @(negedge clk);
        frame_stb  = s;
        din        = x;
        cfg_delay  = DW'(d);
        cfg_interp = m;
        @(posedge clk);
        model_step(s, x, d, m);
        #1;
        check(tag, "out_valid", int'(out_valid), int'(e_valid));
        check(tag, "out_sample", int'(out_sample), int'(e_sample));
        check("R5", "osc_upd", int'(osc_upd), int'(e_osc));
        check(tag, "integ_upd", int'(integ_upd), int'(e_integ));
    endtask

    // one frame of len clocks, stream k carries base+k
    task automatic frame(input int len, input int d, input bit m,
                         input logic [SW-1:0] base, input string tag);
        for (int k = 0; k < len; k++) begin
            cyc(k == 0, base + SW'(k), d, m, tag);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_errors++;
        $display("FAIL watchdog expired actual=hang expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        // R1: reset values
        repeat (3) @(posedge clk);
        #1;
        check("R1", "out_sample", int'(out_sample), 0);
        check("R1", "out_valid", int'(out_valid), 0);
        check("R1", "osc_upd", int'(osc_upd), 0);
        check("R1", "integ_upd", int'(integ_upd), 0);
        @(negedge clk);
        rst_n = 1'b1;
        cyc(1'b0, 16'h1234, 0, 1'b0, "R1");

        // R10: first strobe after reset has nothing to hand on
        frame(8, 3, 1'b0, 16'h0100, "R10");
        // R3: delivered at next strobe; value 0x0103
        frame(8, 0, 1'b0, 16'h0200, "R3");
        // R2: delay 0 takes 0x0200
        frame(8, 5, 1'b0, 16'h0300, "R2");

        // R3: sweep all delays, gated
        for (int d = 0; d < 8; d++) frame(8, d, 1'b0, SW'(16'h1000 + d * 16), "R3");
        // R7: interpolated sweep
        for (int d = 0; d < 8; d++) frame(8, 7 - d, 1'b1, SW'(16'h8000 + d * 16), "R7");
        // R6: back to gated, value held
        frame(6, 2, 1'b0, 16'h4000, "R6");
        frame(6, 4, 1'b0, 16'h5000, "R6");

        // R8: frame shorter than the delay, then a normal frame
        frame(3, 6, 1'b0, 16'h6000, "R8");
        frame(8, 1, 1'b0, 16'h6100, "R8");
        frame(8, 1, 1'b0, 16'h6200, "R8");
        // R8: back-to-back strobes
        cyc(1'b1, 16'h7000, 2, 1'b1, "R8");
        cyc(1'b1, 16'h7001, 2, 1'b1, "R8");
        frame(5, 0, 1'b1, 16'h7100, "R8");

        // R9: settings change mid-frame must not matter
        cyc(1'b1, 16'h2000, 4, 1'b0, "R9");
        cyc(1'b0, 16'h2001, 1, 1'b1, "R9");
        cyc(1'b0, 16'h2002, 0, 1'b1, "R9");
        cyc(1'b0, 16'h2003, 7, 1'b1, "R9");
        cyc(1'b0, 16'h2004, 2, 1'b1, "R9");
        cyc(1'b0, 16'h2005, 2, 1'b1, "R9");
        frame(6, 0, 1'b0, 16'h2100, "R9");

        // R4: random frames, random settings churn between strobes
        void'($urandom(32'd7331));
        for (int f = 0; f < 600; f++) begin
            int len;
            int d;
            bit m;
            len = 1 + int'($urandom_range(9));
            d   = int'($urandom_range(7));
            m   = 1'($urandom_range(1));
            for (int k = 0; k < len; k++) begin
                if (k == 0) cyc(1'b1, SW'($urandom), d, m, "R4");
                else cyc(1'b0, SW'($urandom), int'($urandom_range(7)),
                         1'($urandom_range(1)), "R4");
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule